// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Timer with Two Compare Channels

This block is a 16-bit up-counter with two 16-bit compare channels. An 8-bit CPU register bus reaches all of them. The bus carries one byte per access, so a single shared temporary byte register holds half of a 16-bit value between the two accesses. This lets software see and set each 16-bit register as one coherent value. On writes the upper byte is parked first and the lower byte commits the whole word. On reads the lower byte is fetched first, and that fetch freezes a copy of the upper byte.

The counter advances by one on every cycle in which the timer tick input is high. Software can preset the counter. After a preset, the first tick that follows still counts, but no compare match can occur on that tick. This keeps initialisation from causing an immediate interrupt. Each channel compares its value with the counter on every tick. A hit sets a per-channel interrupt flag one clock after the compare event, and software clears the flag by writing a one to it.

Top module: `tmr16_cmp`

## Requirements
- R1: A bus write to address 1 (counter upper byte) stores the byte in the shared temporary register and leaves the counter unchanged.
- R2: A bus write to address 0 (counter lower byte) loads the counter in one step. The upper half comes from the temporary register and the lower half from the written byte.
- R3: A bus read of address 0 returns the live counter lower byte on rdata_o in the same cycle. At that clock edge it also copies the live counter upper byte into the temporary register.
- R4: A bus read of address 1 returns the temporary register, not the live counter upper byte.
- R5: Compare channel A uses address 3 for its upper byte and address 2 for its lower byte; channel B uses addresses 5 and 4. A write to the upper address changes only the shared temporary register. A write to the lower address loads both halves of that compare register together, with the upper half taken from the temporary register. Both addresses read the compare register's own bytes directly.
- R6: The counter adds one, modulo 2^16 (0xFFFF wraps to 0x0000), on each cycle with tick_i high. Without a tick it holds its value. After a preset it resumes counting from the preset value on the next tick.
- R7: A write to address 0 suppresses compare events on the first tick that follows it. A tick in the same cycle as that write is also suppressed.
- R8: A compare event is a tick cycle, not suppressed, in which the counter equals a channel's compare value. The clock edge that ends the event cycle does not yet change the flag. The following edge sets that channel's flag (flag_o bit 0 is channel A, bit 1 is channel B).
- R9: A flag never sets while no tick occurs, and it never sets if the counter does not reach that channel's compare value.
- R10: Address 6 reads back the flags in bits 0 (A) and 1 (B), with all other bits zero. Writing a one to a bit clears that flag, and a zero bit has no effect. If a clear and a flag-setting event hit the same cycle, the flag stays set.
- R11: After reset the counter, both compare registers, the temporary register and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer clock enable, one count per high cycle |
| addr_i | input | 3 | Register byte address |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data, combinational from address |
| flag_o | output | 2 | Compare interrupt flags, bit 0 channel A, bit 1 channel B |

## Verification
A table of presets and tick counts exercises the counting path. It covers a plain step, a carry from the lower into the upper byte, the wrap through 0xFFFF, a zero-tick hold and a carry into the top bit, which separates a correct 16-bit increment from byte-wise or non-wrapping counting. Directed sequences then separate the temporary register from the live counter. They read the upper byte after the counter has moved, read it right after an upper-byte write, and commit a compare register with a temporary byte that was staged through the counter address. Flag tests place the compare value at the preset value, at a value reached after several ticks, at a value never reached, and at a value matched with no tick present. They also sample the flag one cycle apart to pin its latency, and time a clear to land on the same cycle as a new match.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_LO,
        RK_HI,
        RK_FLAG
    } reg_kind_e;

    localparam int unsigned CMP_BASE = 2;

    function automatic int unsigned flag_addr(int unsigned n_ch);
        return CMP_BASE + 2 * n_ch;
    endfunction

    function automatic reg_kind_e kind_of(int unsigned a, int unsigned n_ch);
        if (a == flag_addr(n_ch)) return RK_FLAG;
        if (a > flag_addr(n_ch))  return RK_NONE;
        return (a[0]) ? RK_HI : RK_LO;
    endfunction

endpackage

// File: rtl/tmr16_bus.sv
module tmr16_bus
    import tmr16_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int N_CH   = 2,
    localparam int CNT_W  = 2 * BYTE_W,
    localparam int ADDR_W = $clog2(2 * N_CH + 3)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       wr_i,
    input  logic                       rd_i,
    input  logic [BYTE_W-1:0]          wdata_i,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic [N_CH-1:0][CNT_W-1:0] cmp_i,
    input  logic [N_CH-1:0]            flag_i,
    output logic [BYTE_W-1:0]          rdata_o,
    output logic [BYTE_W-1:0]          temp_o,
    output logic                       cnt_ld_o,
    output logic [N_CH-1:0]            cmp_ld_o,
    output logic [CNT_W-1:0]           ld_val_o,
    output logic [N_CH-1:0]            flag_clr_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] temp;
    } bus_st_t;

    bus_st_t     st_d, st_q;
    int unsigned a;
    reg_kind_e   kind;

    always_comb begin
        a          = 32'(addr_i);
        kind       = kind_of(a, N_CH);
        st_d       = st_q;
        rdata_o    = '0;
        cnt_ld_o   = wr_i && (a == 0);
        cmp_ld_o   = '0;
        flag_clr_o = '0;
        ld_val_o   = {st_q.temp, wdata_i};

        // temporary byte: upper-byte writes fill it, counter low reads snapshot it
        if (wr_i && kind == RK_HI) begin
            st_d.temp = wdata_i;
        end else if (rd_i && !wr_i && a == 0) begin
            st_d.temp = cnt_i[CNT_W-1:BYTE_W];
        end

        if (a == 0) rdata_o = cnt_i[BYTE_W-1:0];
        if (a == 1) rdata_o = st_q.temp;

        for (int k = 0; k < N_CH; k++) begin
            if (a == CMP_BASE + 2 * k) begin
                rdata_o     = cmp_i[k][BYTE_W-1:0];
                cmp_ld_o[k] = wr_i;
            end
            if (a == CMP_BASE + 2 * k + 1) begin
                rdata_o = cmp_i[k][CNT_W-1:BYTE_W];
            end
            if (kind == RK_FLAG) begin
                rdata_o[k]    = flag_i[k];
                flag_clr_o[k] = wr_i && wdata_i[k];
            end
        end

        temp_o = st_q.temp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_en_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             blk;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.cnt = ld_val_i;
            st_d.blk = 1'b1;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.blk = 1'b0;
        end
        evt_en_o = tick_i && !st_q.blk && !ld_i;
        cnt_o    = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             evt_en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             hit_o,
    output logic             flag_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             hit;
        logic             flag;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        if (ld_i) st_d.cmp = ld_val_i;
        st_d.hit  = evt_en_i && (cnt_i == st_q.cmp);
        st_d.flag = st_q.hit || (st_q.flag && !clr_i);
        cmp_o     = st_q.cmp;
        hit_o     = st_q.hit;
        flag_o    = st_q.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr16_cmp.sv
module tmr16_cmp #(
    parameter int BYTE_W = 8,
    parameter int N_CH   = 2,
    localparam int CNT_W  = 2 * BYTE_W,
    localparam int ADDR_W = $clog2(2 * N_CH + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [N_CH-1:0]   flag_o
);

    logic [CNT_W-1:0]           cnt_q;
    logic [N_CH-1:0][CNT_W-1:0] cmp_all;
    logic [BYTE_W-1:0]          temp_q;
    logic                       cnt_ld;
    logic [N_CH-1:0]            cmp_ld;
    logic [CNT_W-1:0]           ld_val;
    logic [N_CH-1:0]            flag_clr;
    logic [N_CH-1:0]            hit;
    logic                       evt_en;

    tmr16_bus #(.BYTE_W(BYTE_W), .N_CH(N_CH)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .wdata_i    (wdata_i),
        .cnt_i      (cnt_q),
        .cmp_i      (cmp_all),
        .flag_i     (flag_o),
        .rdata_o    (rdata_o),
        .temp_o     (temp_q),
        .cnt_ld_o   (cnt_ld),
        .cmp_ld_o   (cmp_ld),
        .ld_val_o   (ld_val),
        .flag_clr_o (flag_clr)
    );

    tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .ld_i     (cnt_ld),
        .ld_val_i (ld_val),
        .cnt_o    (cnt_q),
        .evt_en_o (evt_en)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        tmr16_chan #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_i     (cmp_ld[k]),
            .ld_val_i (ld_val),
            .evt_en_i (evt_en),
            .cnt_i    (cnt_q),
            .clr_i    (flag_clr[k]),
            .cmp_o    (cmp_all[k]),
            .hit_o    (hit[k]),
            .flag_o   (flag_o[k])
        );
    end

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
    parameter int BYTE_W = 8,
    parameter int N_CH   = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic [BYTE_W-1:0] wdata_i,
    input logic [BYTE_W-1:0] rdata_o,
    input logic [N_CH-1:0]   flag_o,
    input logic [BYTE_W-1:0] temp_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [N_CH-1:0]   hit
);

    localparam int FLAG_A = 2 + 2 * N_CH;

    logic lo_wr, hi_wr, lo_rd, hi_rd, flg_wr;
    assign lo_wr  = wr_i && (32'(addr_i) == 0);
    assign hi_wr  = wr_i && (32'(addr_i) == 1);
    assign lo_rd  = rd_i && !wr_i && (32'(addr_i) == 0);
    assign hi_rd  = rd_i && (32'(addr_i) == 1);
    assign flg_wr = wr_i && (32'(addr_i) == FLAG_A);

    p_hi_write_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr && !tick_i |=> cnt_q == $past(cnt_q));

    p_lo_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> cnt_q == {$past(temp_q), $past(wdata_i)});

    p_lo_read_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |-> rdata_o == cnt_q[BYTE_W-1:0]);

    p_lo_read_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> temp_q == $past(cnt_q[CNT_W-1:BYTE_W]));

    p_hi_read_temp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |-> rdata_o == temp_q);

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !lo_wr |=> cnt_q == $past(cnt_q) + 1'b1);

    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !lo_wr |=> cnt_q == $past(cnt_q));

    p_no_event_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> hit == '0);

    for (genvar k = 0; k < N_CH; k++) begin : g_fl
        p_flag_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hit[k] |=> flag_o[k]);

        p_flag_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_o[k]) |-> $past(hit[k]));

        p_no_hit_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_i |=> !hit[k]);

        p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            flg_wr && wdata_i[k] && !hit[k] |=> !flag_o[k]);
    end

endmodule

bind tmr16_cmp tmr16_chk #(
    .BYTE_W(BYTE_W), .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .flag_o  (flag_o),
    .temp_q  (temp_q),
    .cnt_q   (cnt_q),
    .hit     (hit)
);

// File: tb/tmr16_cmp_tb.sv
`timescale 1ns/1ps
module tmr16_cmp_tb;

    localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_ALO = 3'd2, A_AHI = 3'd3,
                           A_BLO = 3'd4, A_BHI = 3'd5, A_FLG = 3'd6;

    // {preset[15:0], ticks[7:0], expected[15:0]}
    localparam logic [39:0] VEC [5] = '{
        {16'h1234, 8'd3, 16'h1237},
        {16'hFFFE, 8'd3, 16'h0001},
        {16'h00FF, 8'd1, 16'h0100},
        {16'hABCD, 8'd0, 16'hABCD},
        {16'h7FFF, 8'd2, 16'h8001}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic       wr_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic [1:0] flag_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    tmr16_cmp u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .addr_i  (addr_i),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .flag_o  (flag_o)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_wr(logic [2:0] a, logic [7:0] d);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic bus_rd(logic [2:0] a, output logic [7:0] d);
        addr_i = a; rd_i = 1'b1;
        #1 d = rdata_o;
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    task automatic tick_once();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr16(logic [2:0] lo_a, logic [15:0] v);
        bus_wr(lo_a + 3'd1, v[15:8]);
        bus_wr(lo_a, v[7:0]);
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(A_CLO, lo);
        bus_rd(A_CHI, hi);
        v = {hi, lo};
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%04h expected 0x%04h", 16'd0, 16'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state, every address reads zero
        for (int a = 0; a < 7; a++) begin
            bus_rd(3'(a), b);
            chk("R11 reset readback", {8'h0, b}, 16'h0);
        end
        chk("R11 reset flags", {14'h0, flag_o}, 16'h0);

        // R2 / R6: preset and tick table
        for (int i = 0; i < 5; i++) begin
            wr16(A_CLO, VEC[i][39:24]);
            for (int t = 0; t < int'(VEC[i][23:16]); t++) tick_once();
            read16(w);
            chk("R2/R6 preset then count", w, VEC[i][15:0]);
        end
        bus_wr(A_FLG, 8'h03);
        chk("R10 clear both", {14'h0, flag_o}, 16'h0);

        // R6: holds without ticks
        idle(5);
        read16(w);
        chk("R6 hold without tick", w, 16'h8001);

        // R7: preset equal to compare, first tick suppressed
        wr16(A_ALO, 16'h0100);
        wr16(A_CLO, 16'h0100);
        tick_once();
        idle(2);
        chk("R7 suppressed match", {15'h0, flag_o[0]}, 16'h0);
        read16(w);
        chk("R6 resume after preset", w, 16'h0101);

        // R8: latency of flag
        wr16(A_BLO, 16'h01FF);
        wr16(A_CLO, 16'h01FD);
        tick_once();
        tick_once();
        tick_once();
        chk("R8 flag not yet set", {15'h0, flag_o[1]}, 16'h0);
        idle(1);
        chk("R8 flag set one cycle later", {15'h0, flag_o[1]}, 16'h1);
        chk("R9 unreached compare A", {15'h0, flag_o[0]}, 16'h0);
        bus_rd(A_FLG, b);
        chk("R10 flag readback", {8'h0, b}, 16'h0002);

        // R10: clear semantics
        bus_wr(A_FLG, 8'h01);
        chk("R10 clear other bit only", {14'h0, flag_o}, 16'h2);
        bus_wr(A_FLG, 8'h00);
        chk("R10 zero write no effect", {14'h0, flag_o}, 16'h2);
        wr16(A_BLO, 16'h0200);
        tick_once();
        bus_wr(A_FLG, 8'h02);
        chk("R10 clear collides with match", {15'h0, flag_o[1]}, 16'h1);
        bus_wr(A_FLG, 8'h02);
        chk("R10 clear", {15'h0, flag_o[1]}, 16'h0);

        // R9: equal value but no tick
        wr16(A_ALO, 16'h0201);
        idle(4);
        chk("R9 no tick no flag", {15'h0, flag_o[0]}, 16'h0);
        tick_once();
        idle(1);
        chk("R8 match without preset", {15'h0, flag_o[0]}, 16'h1);

        // R4 / R1
        bus_wr(A_CHI, 8'h5A);
        bus_rd(A_CHI, b);
        chk("R4 high read returns temp", {8'h0, b}, 16'h005A);
        read16(w);
        chk("R1 high write leaves counter", w, 16'h0202);

        // R3: low read snapshots high byte
        wr16(A_CLO, 16'h12FF);
        bus_rd(A_CLO, b);
        chk("R3 low read live", {8'h0, b}, 16'h00FF);
        tick_once();
        bus_rd(A_CHI, b);
        chk("R3 high byte frozen copy", {8'h0, b}, 16'h0012);
        read16(w);
        chk("R3 coherent pair", w, 16'h1300);

        // R5: compare register access
        bus_wr(A_AHI, 8'h77);
        bus_rd(A_AHI, b);
        chk("R5 high write staged only", {8'h0, b}, 16'h0002);
        bus_rd(A_ALO, b);
        chk("R5 low unchanged", {8'h0, b}, 16'h0001);
        bus_wr(A_ALO, 8'h10);
        bus_rd(A_AHI, b);
        chk("R5 high committed", {8'h0, b}, 16'h0077);
        bus_rd(A_ALO, b);
        chk("R5 low committed", {8'h0, b}, 16'h0010);
        bus_wr(A_CHI, 8'h3C);
        bus_wr(A_BLO, 8'h44);
        bus_rd(A_BHI, b);
        chk("R5 shared temp high", {8'h0, b}, 16'h003C);
        bus_rd(A_BLO, b);
        chk("R5 shared temp low", {8'h0, b}, 16'h0044);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule